// File: doc/BRIEF.md
# Serial EEPROM Pin Arbitration Port

This block sits between a host control register and the four pins of a three-wire serial EEPROM: chip select, serial clock, data toward the memory, and data back from it. Software can drive the chip-select, clock and data lines directly, one register write per edge, and so run the serial protocol bit by bit. When hardware reset is held, or when an automatic read engine owns the memory, host control is locked out.

All pin outputs are registered on the bus clock. Exactly one source is chosen each cycle, in this priority order:

- **Hardware reset.** Chip select goes low, the busy flag goes high, and the clock and data pins are released (output enable low).
- **Automatic read engine.** It wins when the preload bit is set or when the engine reports that a read is in progress. It then drives every pin and the busy flag, whatever the enable bit holds.
- **Host.** It wins when the enable bit is set. The pins then copy the register bits and the busy flag copies the register's busy bit.
- **Idle.** With none of the above, all pins and busy are held low.

The data-return pin passes through a two-stage synchronizer before it can be read back in the register. The register is a plain write-enable / combinational-read control port. No data stream passes through the block, so it has no valid/ready handshake. A write is accepted on every clock edge where the write enable is high, with no back-pressure.

Top module: `eep_pin_port`

## Requirements
- R1: Hardware reset loads the register to: clock bit 1, and chip-select, data, busy, enable and preload bits 0. The register then reads 32'h0000_0002, with the synchronizer also cleared. The field positions are: bit 0 = data (write: value for the data pin, read: synchronized return pin), bit 1 = clock, bit 2 = chip select, bit 3 = busy, bit 4 = enable, bit 5 = preload.
- R2: While `rst_hw` is high, `ee_cs` is 0, `busy` is 1, and `ee_sk_oe` and `ee_di_oe` are 0.
- R3: In host mode (preload 0, `ar_active` 0, enable 1), `ee_cs`, `ee_sk` and `ee_di` take the register values. A write lands in the register on the edge where `wr_en` is sampled, and reaches the pins on the following rising edge.
- R4: When preload is 1 or `ar_active` is 1, `ee_cs`, `ee_sk`, `ee_di` and `busy` take `ar_cs`, `ar_sk`, `ar_di` and `ar_busy` one edge later, regardless of the enable bit.
- R5: When preload is 0, `ar_active` is 0 and enable is 0, `ee_cs`, `ee_sk`, `ee_di` and `busy` are all 0 one edge later.
- R6: In host mode, `busy` follows the register's busy bit (bit 3) one edge later.
- R7: Read bit 0 returns the level of `ee_do` delayed by two rising edges, not the last value written to bit 0.
- R8: Bits 31 to 6 always read 0, and writing 1s to them changes nothing else.
- R9: A single write that changes both clock and data moves `ee_sk` and `ee_di` on the same rising edge.
- R10: Out of hardware reset, `ee_sk_oe` and `ee_di_oe` are 1 from the first rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_hw | input | 1 | Hardware reset, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| ar_active | input | 1 | Automatic read in progress |
| ar_cs | input | 1 | Chip-select value from the read engine |
| ar_sk | input | 1 | Clock value from the read engine |
| ar_di | input | 1 | Data value from the read engine |
| ar_busy | input | 1 | Busy value from the read engine |
| ee_do | input | 1 | Data returned by the EEPROM (asynchronous) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_sk_oe | output | 1 | Output enable for `ee_sk` |
| ee_di | output | 1 | EEPROM data in |
| ee_di_oe | output | 1 | Output enable for `ee_di` |
| busy | output | 1 | Busy flag from the selected source |

## Verification
The clocked properties assume that `wr_en`, `wr_data` and the read-engine inputs are stable around each rising edge. They also assume that `rst_hw` is raised or lowered away from an edge. The bench meets this by changing every input on the falling edge only. The reset property is sampled on falling edges, so it only needs `rst_hw` to have settled by then. `ee_do` is treated as fully asynchronous, and no property depends on it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned BIT_DIO = 0;
  localparam int unsigned BIT_SK  = 1;
  localparam int unsigned BIT_CS  = 2;
  localparam int unsigned BIT_BSY = 3;
  localparam int unsigned BIT_EN  = 4;
  localparam int unsigned BIT_PRE = 5;
  localparam int unsigned FIELD_W = 6;

  typedef struct packed {
    logic pre;
    logic en;
    logic bsy;
    logic cs;
    logic sk;
    logic di;
  } ctl_t;

  typedef struct packed {
    logic busy;
    logic cs;
    logic sk;
    logic di;
  } pin_t;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_HOST = 2'd1,
    SRC_AUTO = 2'd2
  } src_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_hw,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst_hw) begin
        if (rst_hw) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or posedge rst_hw) begin
        if (rst_hw) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eep_ctl_reg.sv
module eep_ctl_reg
  import eep_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_hw,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          dout_s,
  output ctl_t          ctl_q,
  output logic [DW-1:0] rd_data
);
  localparam ctl_t CTL_RST = '{pre: 1'b0, en: 1'b0, bsy: 1'b0,
                               cs: 1'b0, sk: 1'b1, di: 1'b0};

  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:FIELD_W];

  always_ff @(posedge clk or posedge rst_hw) begin
    if (rst_hw) begin
      ctl_q <= CTL_RST;
    end else if (wr_en) begin
      ctl_q.pre <= wr_data[BIT_PRE];
      ctl_q.en  <= wr_data[BIT_EN];
      ctl_q.bsy <= wr_data[BIT_BSY];
      ctl_q.cs  <= wr_data[BIT_CS];
      ctl_q.sk  <= wr_data[BIT_SK];
      ctl_q.di  <= wr_data[BIT_DIO];
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_DIO] = dout_s;
    rd_data[BIT_SK]  = ctl_q.sk;
    rd_data[BIT_CS]  = ctl_q.cs;
    rd_data[BIT_BSY] = ctl_q.bsy;
    rd_data[BIT_EN]  = ctl_q.en;
    rd_data[BIT_PRE] = ctl_q.pre;
  end

  // R3: a write reaches the register on the edge where it is sampled
  p_wr_land_r3: assert property (@(posedge clk) disable iff (rst_hw)
    wr_en |=> (ctl_q.sk == $past(wr_data[BIT_SK]) && ctl_q.cs == $past(wr_data[BIT_CS])));

  // R8: the upper read bits stay zero
  p_hi_zero_r8: assert property (@(posedge clk) disable iff (rst_hw)
    rd_data[DW-1:FIELD_W] == '0);
endmodule

// File: rtl/eep_pin_mux.sv
module eep_pin_mux
  import eep_pkg::*;
(
  input  logic clk,
  input  logic rst_hw,
  input  ctl_t ctl,
  input  logic ar_active,
  input  pin_t ar_pins,
  output pin_t pins_q,
  output logic oe_q
);
  localparam pin_t PIN_RST = '{busy: 1'b1, cs: 1'b0, sk: 1'b0, di: 1'b0};

  src_e src;
  pin_t pins_d;

  always_comb begin
    if (ctl.pre || ar_active) src = SRC_AUTO;
    else if (ctl.en)          src = SRC_HOST;
    else                      src = SRC_OFF;
  end

  always_comb begin
    unique case (src)
      SRC_AUTO: pins_d = ar_pins;
      SRC_HOST: pins_d = '{busy: ctl.bsy, cs: ctl.cs, sk: ctl.sk, di: ctl.di};
      default:  pins_d = '0;
    endcase
  end

  always_ff @(posedge clk or posedge rst_hw) begin
    if (rst_hw) begin
      pins_q <= PIN_RST;
      oe_q   <= 1'b0;
    end else begin
      pins_q <= pins_d;
      oe_q   <= 1'b1;
    end
  end

  // R2: pin state while hardware reset is held
  always_ff @(negedge clk) begin
    if (rst_hw) begin
      p_rst_pins_r2: assert (!pins_q.cs && pins_q.busy && !oe_q);
    end
  end

  p_auto_r4: assert property (@(posedge clk) disable iff (rst_hw)
    (ctl.pre || ar_active) |=> (pins_q == $past(ar_pins)));

  p_host_r3: assert property (@(posedge clk) disable iff (rst_hw)
    (!ctl.pre && !ar_active && ctl.en) |=>
      (pins_q.cs == $past(ctl.cs) && pins_q.sk == $past(ctl.sk) && pins_q.di == $past(ctl.di)));

  p_busy_host_r6: assert property (@(posedge clk) disable iff (rst_hw)
    (!ctl.pre && !ar_active && ctl.en) |=> (pins_q.busy == $past(ctl.bsy)));

  p_off_r5: assert property (@(posedge clk) disable iff (rst_hw)
    (!ctl.pre && !ar_active && !ctl.en) |=> (pins_q == '0));

  p_oe_r10: assert property (@(posedge clk) disable iff (rst_hw)
    1'b1 |=> oe_q);
endmodule

// File: rtl/eep_pin_port.sv
module eep_pin_port
  import eep_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_hw,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ar_active,
  input  logic          ar_cs,
  input  logic          ar_sk,
  input  logic          ar_di,
  input  logic          ar_busy,
  input  logic          ee_do,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_sk_oe,
  output logic          ee_di,
  output logic          ee_di_oe,
  output logic          busy
);
  ctl_t ctl_q;
  pin_t ar_pins;
  pin_t pins_q;
  logic oe_q;
  logic dout_s;

  assign ar_pins = '{busy: ar_busy, cs: ar_cs, sk: ar_sk, di: ar_di};

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_hw  (rst_hw),
    .d_async (ee_do),
    .q_sync  (dout_s)
  );

  eep_ctl_reg #(.DW(DW)) u_reg (
    .clk     (clk),
    .rst_hw  (rst_hw),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dout_s  (dout_s),
    .ctl_q   (ctl_q),
    .rd_data (rd_data)
  );

  eep_pin_mux u_mux (
    .clk       (clk),
    .rst_hw    (rst_hw),
    .ctl       (ctl_q),
    .ar_active (ar_active),
    .ar_pins   (ar_pins),
    .pins_q    (pins_q),
    .oe_q      (oe_q)
  );

  assign ee_cs    = pins_q.cs;
  assign ee_sk    = pins_q.sk;
  assign ee_di    = pins_q.di;
  assign busy     = pins_q.busy;
  assign ee_sk_oe = oe_q;
  assign ee_di_oe = oe_q;
endmodule

// File: tb/eep_pin_port_tb.sv
`timescale 1ns/1ps
module eep_pin_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_hw;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ar_active, ar_cs, ar_sk, ar_di, ar_busy;
  logic        ee_do;
  logic        ee_cs, ee_sk, ee_sk_oe, ee_di, ee_di_oe, busy;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model of the register: {pre,en,bsy,cs,sk,di}
  logic [5:0] m_reg;

  always #2.5 clk = ~clk;

  eep_pin_port dut_i (
    .clk(clk), .rst_hw(rst_hw), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ar_active(ar_active), .ar_cs(ar_cs), .ar_sk(ar_sk), .ar_di(ar_di), .ar_busy(ar_busy),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_sk_oe(ee_sk_oe),
    .ee_di(ee_di), .ee_di_oe(ee_di_oe), .busy(busy)
  );

  // expected {busy,cs,sk,di} one edge after the given state
  function automatic logic [3:0] f_pins(logic [5:0] r, logic act, logic [3:0] arp);
    if (r[5] || act) return arp;
    if (r[4])        return {r[3], r[2], r[1], r[0]};
    return 4'b0000;
  endfunction

  function automatic logic [31:0] f_rd(logic [5:0] r, logic dsync);
    return {26'd0, r[5:1], dsync};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    step();
    wr_en   = 1'b0;
    m_reg   = d[5:0];
  endtask

  initial begin : watchdog
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h00C0FFEE));
    rst_hw = 1'b1; wr_en = 1'b0; wr_data = '0;
    ar_active = 0; ar_cs = 0; ar_sk = 0; ar_di = 0; ar_busy = 0; ee_do = 0;
    m_reg = 6'b000010;
    repeat (3) step();

    // R2 and R1 during reset
    chk("R2 cs/busy/oe", {ee_cs, busy, ee_sk_oe, ee_di_oe}, 4'b0100);
    chk("R1 reset readback", rd_data, 32'h0000_0002);

    rst_hw = 1'b0;
    step();
    chk("R10 oe after reset", {ee_sk_oe, ee_di_oe}, 2'b11);
    chk("R5 idle pins", {busy, ee_cs, ee_sk, ee_di}, 4'b0000);

    // R3/R6 host mode: en=1 bsy=1 cs=1 sk=0 di=1 -> 0x1D
    wr(32'h0000_001D);
    chk("R3 pins not yet moved", {ee_cs, ee_di}, 2'b00);
    step();
    chk("R3 host pins", {ee_cs, ee_sk, ee_di}, 3'b101);
    chk("R6 host busy", busy, 1'b1);

    // R9 clock and data change in one write: sk 0->1, di 1->0 -> 0x1E
    wr(32'h0000_001E);
    chk("R9 both still old", {ee_sk, ee_di}, 2'b01);
    step();
    chk("R9 both moved same edge", {ee_sk, ee_di}, 2'b10);

    // R8 upper bits ignored: 0xFFFFFFD6 -> fields 0x16
    wr(32'hFFFF_FFD6);
    chk("R8 readback", rd_data, 32'h0000_0016);
    step();
    chk("R8 pins unaffected", {busy, ee_cs, ee_sk, ee_di}, 4'b0110);

    // R7 readback is synchronized ee_do, not written data bit
    wr(32'h0000_0017);
    chk("R7 written bit not read", rd_data[0], 1'b0);
    ee_do = 1'b1;
    step();
    chk("R7 one edge: old level", rd_data[0], 1'b0);
    step();
    chk("R7 two edges: new level", rd_data[0], 1'b1);
    ee_do = 1'b0;
    step();
    step();
    chk("R7 return to low", rd_data[0], 1'b0);

    // R4 preload with enable off (0x20)
    wr(32'h0000_0020);
    ar_cs = 1; ar_sk = 0; ar_di = 1; ar_busy = 1;
    step();
    chk("R4 preload overrides", {busy, ee_cs, ee_sk, ee_di}, 4'b1101);
    // R4 ar_active with host enabled (0x16)
    wr(32'h0000_0016);
    ar_active = 1; ar_cs = 0; ar_sk = 1; ar_di = 0; ar_busy = 0;
    step();
    chk("R4 active overrides enable", {busy, ee_cs, ee_sk, ee_di}, 4'b0010);
    ar_active = 0;
    step();
    chk("R3 host regains pins", {busy, ee_cs, ee_sk, ee_di}, 4'b0110);

    // random mix of all three sources
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  exp_p;
      logic [31:0] d;
      ar_active = ($urandom_range(0, 3) == 0);
      {ar_busy, ar_cs, ar_sk, ar_di} = 4'($urandom);
      exp_p = f_pins(m_reg, ar_active, {ar_busy, ar_cs, ar_sk, ar_di});
      if ($urandom_range(0, 2) == 0) begin
        d = $urandom;
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; m_reg = d[5:0];
      end else begin
        step();
      end
      chk("R3/R4/R5/R6 random pins", {busy, ee_cs, ee_sk, ee_di}, exp_p);
      chk("R8 random readback", rd_data, f_rd(m_reg, 1'b0));
    end

    // R2/R1 again: reset raised mid-run acts at once
    wr(32'h0000_001F);
    #1 rst_hw = 1'b1;
    #1;
    chk("R2 async reset pins", {ee_cs, busy, ee_sk_oe, ee_di_oe}, 4'b0100);
    chk("R1 register reset mid-run", rd_data, 32'h0000_0002);
    step();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule